// File: doc/BRIEF.md
# Partial Reconfiguration Load Sequencer

This block supervises one reconfigurable partition of a device. A load request arrives either as a pulse on one of several hardware trigger lines or as a software trigger that carries a trigger number. A trigger map turns the trigger number into a reconfigurable-module (RM) number. A per-module table then supplies the module's image start address and its length in bytes. The sequencer takes the partition out of service and reads the image as 32-bit words from a single-outstanding memory read port. It forwards every good word to a configuration-port write interface that uses a valid/ready handshake. After that it holds the module reset for a fixed number of cycles and reports the module as loaded.

Alongside loads, the block accepts two commands: shutdown, which parks the partition, and restart, which brings it back. It reports a 3-bit state, a 4-bit error code, a shutdown flag and the number of the module that is currently loaded. The trigger map and the module table are static inputs, and they may change only while no load is running.

Top module: `pr_load_seq`

## Requirements
- R1: After reset the state reads 0 (empty) and the error reads 0. The shutdown flag, the module reset, the memory request and the configuration valid are all low.
- R2: Each hardware trigger line i (pulse high for one cycle) and the software trigger (strobe plus trigger number) are looked up through the trigger map to obtain an RM number. The software trigger wins over hardware lines in the same cycle, and among hardware lines the lowest index wins.
- R3: An accepted trigger puts the state at 1 (hardware shutdown) for exactly one cycle. The state is then 4 (loading) for the whole transfer, then 6 (module reset) for RESET_CYCLES cycles with the module reset output high in exactly those cycles, and then 7 (loaded).
- R4: A load of S bytes issues exactly ceil(S/4) reads, at addresses base, base+4, base+8 and so on. Every word read without error is forwarded in order on the configuration port. Address and data stay stable while their handshake is pending.
- R5: After a clean load the state reads 7, the error reads 0, and the reported RM id equals the module just loaded.
- R6: A module whose byte size is 0 ends the request with error 1, state 0, no memory read and no module reset.
- R7: A trigger map entry that names an RM number of NUM_RM or above ends the request with error 15, state 0 and no memory read.
- R8: The configuration port error input raised during loading gives error 2. A read returned with the fetch error flag gives error 4, and that word is not forwarded. Both in one load give error 5. In each case the transfer runs to its end, the state then returns to 0, and the module reset is never raised.
- R9: Triggers that arrive while the state is 1, 4, 5 or 6, or while the state is 2 (software shutdown), are dropped. A command in the same cycle as a trigger also drops the trigger.
- R10: The shutdown command (command strobe with the restart bit 0) is accepted in states 0 and 7. It moves the state to 2 with the shutdown flag high, and the state stays there until a restart command (restart bit 1). Restart then shows state 5 for one cycle, followed by 7 if a module was loaded before the shutdown and 0 otherwise.
- R11: A non-zero error code holds until the next accepted trigger or restart command, either of which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_trig | input | NUM_TRIG | Hardware trigger pulses, one per trigger number |
| sw_trig | input | 1 | Software trigger strobe |
| sw_trig_sel | input | TRIG_W | Trigger number carried by the software trigger |
| cmd_valid | input | 1 | Command strobe |
| cmd_restart | input | 1 | Command kind: 0 shutdown, 1 restart |
| trig_map | input | NUM_TRIG*RM_W | RM number for each trigger, entry i at bits [i*RM_W +: RM_W] |
| rm_base | input | NUM_RM*ADDR_W | Image start address per RM |
| rm_bytes | input | NUM_RM*SIZE_W | Image length in bytes per RM |
| mem_req | output | 1 | Read request, held until mem_rvalid |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rvalid | input | 1 | Read data returned; completes the request |
| mem_rdata | input | DATA_W | Read data |
| mem_rerr | input | 1 | Read failed; qualifies mem_rvalid |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | DATA_W | Configuration word |
| cfg_ready | input | 1 | Configuration port accepts the word |
| cfg_err | input | 1 | Configuration port reports a failure |
| rm_reset | output | 1 | Reset for the freshly loaded module |
| state | output | 3 | Sequencer state code |
| error | output | 4 | Error code |
| shutdown | output | 1 | Partition parked by command |
| rm_id | output | RM_W | Number of the loaded module |

## Verification
A wrong internal state is visible on the state port at the first sampling after the faulty edge, because every state code is driven out directly. A miscounted word counter or address register shows up as a short or long word stream, or as a word whose value does not match its address, on the configuration port before the module reset phase begins. A lost error flag turns into a state 7 with error 0 at the end of that same load, where 2, 4 or 5 was due. A wrong reset timer changes the number of cycles in which rm_reset is high, which the bench counts on every load.

// File: rtl/pr_seq_pkg.sv
// Shared state codes, error codes and helpers for the load sequencer.
package pr_seq_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY    = 3'd0,
        ST_HW_SHUT  = 3'd1,
        ST_SW_SHUT  = 3'd2,
        ST_CLEAR    = 3'd3,
        ST_LOADING  = 3'd4,
        ST_SW_START = 3'd5,
        ST_RM_RESET = 3'd6,
        ST_LOADED   = 3'd7
    } pr_state_e;

    localparam logic [3:0] ERR_NONE       = 4'd0;
    localparam logic [3:0] ERR_BAD_CFG    = 4'd1;
    localparam logic [3:0] ERR_PORT       = 4'd2;
    localparam logic [3:0] ERR_FETCH      = 4'd4;
    localparam logic [3:0] ERR_PORT_FETCH = 4'd5;
    localparam logic [3:0] ERR_UNKNOWN    = 4'd15;

    // Merge the two transfer failure flags into one reported code.
    function automatic logic [3:0] merge_err(input logic port_bad, input logic fetch_bad);
        if (port_bad && fetch_bad) return ERR_PORT_FETCH;
        if (port_bad)              return ERR_PORT;
        if (fetch_bad)             return ERR_FETCH;
        return ERR_NONE;
    endfunction

endpackage

// File: rtl/pr_trig_select.sv
// Trigger arbiter and map lookup.
// Picks one trigger per cycle: the software trigger first, then the lowest
// hardware line. It returns the RM number stored in the map for that trigger.
// Assumes sw_sel < NUM_TRIG.
module pr_trig_select #(
    parameter int NUM_TRIG = 4,
    parameter int RM_W     = 3,
    parameter int TRIG_W   = 2
) (
    input  logic [NUM_TRIG-1:0]      hw_trig,
    input  logic                     sw_trig,
    input  logic [TRIG_W-1:0]        sw_sel,
    input  logic [NUM_TRIG*RM_W-1:0] trig_map,
    output logic                     hit,
    output logic [RM_W-1:0]          rm_sel
);

    logic [TRIG_W-1:0] pick;

    // Priority choice of the trigger number, then the map read.
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int i = NUM_TRIG - 1; i >= 0; i--) begin
            if (hw_trig[i]) begin
                hit  = 1'b1;
                pick = TRIG_W'(i);
            end
        end
        if (sw_trig) begin
            hit  = 1'b1;
            pick = sw_sel;
        end
        rm_sel = trig_map[pick*RM_W +: RM_W];
    end

endmodule

// File: rtl/pr_rm_table.sv
// Module table lookup.
// Returns the image base address and byte length for an RM number. It flags
// numbers that fall outside the table. Purely combinational.
module pr_rm_table #(
    parameter int NUM_RM = 4,
    parameter int RM_W   = 3,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
) (
    input  logic [RM_W-1:0]          rm,
    input  logic [NUM_RM*ADDR_W-1:0] rm_base,
    input  logic [NUM_RM*SIZE_W-1:0] rm_bytes,
    output logic                     rm_ok,
    output logic [ADDR_W-1:0]        base,
    output logic [SIZE_W-1:0]        bytes
);

    localparam int IDX_W = (NUM_RM > 1) ? $clog2(NUM_RM) : 1;

    logic [IDX_W-1:0] idx;

    // Range check, then a clipped index into the flat table.
    always_comb begin
        rm_ok = (32'(rm) < NUM_RM);
        idx   = rm_ok ? IDX_W'(rm) : '0;
        base  = rm_base[idx*ADDR_W +: ADDR_W];
        bytes = rm_ok ? rm_bytes[idx*SIZE_W +: SIZE_W] : '0;
    end

endmodule

// File: rtl/pr_fetch_engine.sv
// Image fetch engine.
// After start it reads start_words words at start_addr, start_addr+4 and so on.
// There is one read in flight and one word of buffering. A word without error
// is forwarded on the configuration port with valid/ready. It records sticky
// flags for fetch errors and configuration port errors until the next start.
// Assumes start is never raised while active.
module pr_fetch_engine #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [SIZE_W-1:0] start_words,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rerr,
    output logic              cfg_valid,
    output logic [DATA_W-1:0] cfg_data,
    input  logic              cfg_ready,
    input  logic              cfg_err,
    output logic              done,
    output logic              port_bad,
    output logic              fetch_bad
);

    logic              active;
    logic              have_word;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] left_q;
    logic [DATA_W-1:0] data_q;

    // Request while words remain and the buffer is free; done once all drained.
    always_comb begin
        mem_req   = active && !have_word && (left_q != '0);
        mem_addr  = addr_q;
        cfg_valid = have_word;
        cfg_data  = data_q;
        done      = active && !have_word && (left_q == '0);
    end

    // Transfer bookkeeping: address, remaining count, buffer and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            have_word <= 1'b0;
            addr_q    <= '0;
            left_q    <= '0;
            data_q    <= '0;
            port_bad  <= 1'b0;
            fetch_bad <= 1'b0;
        end else if (start) begin
            active    <= 1'b1;
            have_word <= 1'b0;
            addr_q    <= start_addr;
            left_q    <= start_words;
            port_bad  <= 1'b0;
            fetch_bad <= 1'b0;
        end else if (active) begin
            if (done) active <= 1'b0;
            if (mem_req && mem_rvalid) begin
                addr_q <= addr_q + ADDR_W'(4);
                left_q <= left_q - SIZE_W'(1);
                if (mem_rerr) begin
                    fetch_bad <= 1'b1;
                end else begin
                    have_word <= 1'b1;
                    data_q    <= mem_rdata;
                end
            end
            if (have_word && cfg_ready) have_word <= 1'b0;
            if (cfg_err) port_bad <= 1'b1;
        end
    end

    // R4: a pending read keeps its request and address.
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R4: a pending configuration word keeps valid and data.
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

endmodule

// File: rtl/pr_load_seq.sv
// Partial reconfiguration load sequencer, top level.
// Accepts triggers and commands and looks up the module to load. It drives
// the fetch engine, times the module reset and reports state, error,
// shutdown and the loaded module number. Assumes the map and table inputs
// change only while the state is 0, 2 or 7. State code 3 is part of the
// encoding but is never entered by this sequencer.
module pr_load_seq
    import pr_seq_pkg::*;
#(
    parameter int NUM_TRIG     = 4,
    parameter int NUM_RM       = 4,
    parameter int RM_W         = 3,
    parameter int ADDR_W       = 32,
    parameter int SIZE_W       = 32,
    parameter int DATA_W       = 32,
    parameter int RESET_CYCLES = 4,
    localparam int TRIG_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TRIG-1:0]        hw_trig,
    input  logic                       sw_trig,
    input  logic [TRIG_W-1:0]          sw_trig_sel,
    input  logic                       cmd_valid,
    input  logic                       cmd_restart,
    input  logic [NUM_TRIG*RM_W-1:0]   trig_map,
    input  logic [NUM_RM*ADDR_W-1:0]   rm_base,
    input  logic [NUM_RM*SIZE_W-1:0]   rm_bytes,
    output logic                       mem_req,
    output logic [ADDR_W-1:0]          mem_addr,
    input  logic                       mem_rvalid,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_rerr,
    output logic                       cfg_valid,
    output logic [DATA_W-1:0]          cfg_data,
    input  logic                       cfg_ready,
    input  logic                       cfg_err,
    output logic                       rm_reset,
    output logic [2:0]                 state,
    output logic [3:0]                 error,
    output logic                       shutdown,
    output logic [RM_W-1:0]            rm_id
);

    localparam int CNT_W = $clog2(RESET_CYCLES + 1);

    pr_state_e         st_q;
    logic [3:0]        err_q;
    logic [RM_W-1:0]   target_q;
    logic [RM_W-1:0]   rm_id_q;
    logic              loaded_q;
    logic              shut_q;
    logic [CNT_W-1:0]  rst_cnt;

    logic              trig_hit;
    logic [RM_W-1:0]   trig_rm;
    logic              tbl_ok;
    logic [ADDR_W-1:0] tbl_base;
    logic [SIZE_W-1:0] tbl_bytes;
    logic [SIZE_W-1:0] tbl_words;
    logic              eng_start;
    logic              eng_done;
    logic              eng_port_bad;
    logic              eng_fetch_bad;
    logic              idle;

    pr_trig_select #(
        .NUM_TRIG (NUM_TRIG),
        .RM_W     (RM_W),
        .TRIG_W   (TRIG_W)
    ) u_trig (
        .hw_trig  (hw_trig),
        .sw_trig  (sw_trig),
        .sw_sel   (sw_trig_sel),
        .trig_map (trig_map),
        .hit      (trig_hit),
        .rm_sel   (trig_rm)
    );

    pr_rm_table #(
        .NUM_RM   (NUM_RM),
        .RM_W     (RM_W),
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W)
    ) u_table (
        .rm       (target_q),
        .rm_base  (rm_base),
        .rm_bytes (rm_bytes),
        .rm_ok    (tbl_ok),
        .base     (tbl_base),
        .bytes    (tbl_bytes)
    );

    // Word count is the byte count rounded up to whole 32-bit words.
    always_comb begin
        tbl_words = SIZE_W'(({1'b0, tbl_bytes} + (SIZE_W + 1)'(3)) >> 2);
        eng_start = (st_q == ST_HW_SHUT) && tbl_ok && (tbl_bytes != '0);
        idle      = (st_q == ST_EMPTY) || (st_q == ST_LOADED);
    end

    pr_fetch_engine #(
        .ADDR_W      (ADDR_W),
        .SIZE_W      (SIZE_W),
        .DATA_W      (DATA_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (eng_start),
        .start_addr  (tbl_base),
        .start_words (tbl_words),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .mem_rerr    (mem_rerr),
        .cfg_valid   (cfg_valid),
        .cfg_data    (cfg_data),
        .cfg_ready   (cfg_ready),
        .cfg_err     (cfg_err),
        .done        (eng_done),
        .port_bad    (eng_port_bad),
        .fetch_bad   (eng_fetch_bad)
    );

    // Main sequencer: commands, trigger acceptance, load phases and reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_EMPTY;
            err_q    <= ERR_NONE;
            target_q <= '0;
            rm_id_q  <= '0;
            loaded_q <= 1'b0;
            shut_q   <= 1'b0;
            rst_cnt  <= '0;
        end else begin
            unique case (st_q)
                ST_EMPTY, ST_LOADED: begin
                    if (cmd_valid) begin
                        if (cmd_restart) begin
                            err_q <= ERR_NONE;
                        end else begin
                            st_q   <= ST_SW_SHUT;
                            shut_q <= 1'b1;
                        end
                    end else if (trig_hit) begin
                        st_q     <= ST_HW_SHUT;
                        target_q <= trig_rm;
                        err_q    <= ERR_NONE;
                        loaded_q <= 1'b0;
                    end
                end
                ST_HW_SHUT: begin
                    if (!tbl_ok) begin
                        st_q  <= ST_EMPTY;
                        err_q <= ERR_UNKNOWN;
                    end else if (tbl_bytes == '0) begin
                        st_q  <= ST_EMPTY;
                        err_q <= ERR_BAD_CFG;
                    end else begin
                        st_q <= ST_LOADING;
                    end
                end
                ST_LOADING: begin
                    if (eng_done) begin
                        if (eng_port_bad || cfg_err || eng_fetch_bad) begin
                            st_q  <= ST_EMPTY;
                            err_q <= merge_err(eng_port_bad || cfg_err, eng_fetch_bad);
                        end else begin
                            st_q    <= ST_RM_RESET;
                            rst_cnt <= '0;
                        end
                    end
                end
                ST_RM_RESET: begin
                    if (rst_cnt == CNT_W'(RESET_CYCLES - 1)) begin
                        st_q     <= ST_LOADED;
                        rm_id_q  <= target_q;
                        loaded_q <= 1'b1;
                        err_q    <= ERR_NONE;
                    end else begin
                        rst_cnt <= rst_cnt + CNT_W'(1);
                    end
                end
                ST_SW_SHUT: begin
                    if (cmd_valid && cmd_restart) begin
                        st_q   <= ST_SW_START;
                        shut_q <= 1'b0;
                        err_q  <= ERR_NONE;
                    end
                end
                ST_SW_START: begin
                    st_q <= loaded_q ? ST_LOADED : ST_EMPTY;
                end
                default: begin
                    st_q <= ST_EMPTY;
                end
            endcase
        end
    end

    // Status outputs straight from the registers.
    always_comb begin
        state    = st_q;
        error    = err_q;
        shutdown = shut_q;
        rm_id    = rm_id_q;
        rm_reset = (st_q == ST_RM_RESET);
    end

    // R5: a loaded module always reports a clean error code.
    assert_loaded_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOADED) |-> (err_q == ERR_NONE));

    // R10: a parked partition issues no traffic and shows its flag.
    assert_parked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SW_SHUT) |-> (shut_q && !mem_req && !cfg_valid));

    // R10: a parked partition stays parked until a restart command arrives.
    assert_parked_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SW_SHUT && !(cmd_valid && cmd_restart)) |=> (st_q == ST_SW_SHUT));

    // R3: hardware shutdown lasts a single cycle.
    assert_hwshut_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HW_SHUT) |=> (st_q != ST_HW_SHUT));

    // R3: the reset timer never passes its limit.
    assert_reset_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RM_RESET) |-> (32'(rst_cnt) < RESET_CYCLES));

    // R9: a transfer in progress is not disturbed by triggers.
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOADING && !eng_done) |=> (st_q == ST_LOADING));

endmodule

// File: tb/tb_pr_load_seq.sv
// Self-checking bench for pr_load_seq: sweeps triggers, sources, stalls and sizes.
module tb_pr_load_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  hw_trig = '0;
    logic        sw_trig = 1'b0;
    logic [1:0]  sw_trig_sel = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_restart = 1'b0;
    logic [11:0] trig_map;
    logic [127:0] rm_base;
    logic [127:0] rm_bytes;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic        cfg_valid;
    logic [31:0] cfg_data;
    logic        cfg_ready = 1'b0;
    logic        cfg_err = 1'b0;
    logic        rm_reset;
    logic [2:0]  state;
    logic [3:0]  error;
    logic        shutdown;
    logic [2:0]  rm_id;

    logic [2:0]  map_b  [4];
    logic [31:0] base_b [4];
    logic [31:0] size_b [4];

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          stall = 0;
    bit          inj_port = 0;
    bit          inj_done = 0;
    bit          fetch_en = 0;
    logic [31:0] fetch_bad_addr = '0;
    logic [31:0] pushed [64];
    int          npush = 0;
    int          rst_hi = 0;

    always #5 clk = ~clk;

    pr_load_seq dut (
        .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .sw_trig(sw_trig),
        .sw_trig_sel(sw_trig_sel), .cmd_valid(cmd_valid), .cmd_restart(cmd_restart),
        .trig_map(trig_map), .rm_base(rm_base), .rm_bytes(rm_bytes),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .cfg_valid(cfg_valid),
        .cfg_data(cfg_data), .cfg_ready(cfg_ready), .cfg_err(cfg_err),
        .rm_reset(rm_reset), .state(state), .error(error), .shutdown(shutdown),
        .rm_id(rm_id)
    );

    // Pack the bench tables onto the flat configuration ports.
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            trig_map[i*3 +: 3]  = map_b[i];
            rm_base[i*32 +: 32]  = base_b[i];
            rm_bytes[i*32 +: 32] = size_b[i];
        end
    end

    function automatic logic [31:0] img(input logic [31:0] a);
        return a ^ 32'h5A00_00C3;
    endfunction

    // Memory and port models, driven just after each rising edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        mem_rvalid = mem_req && (!stall || cyc[1]);
        mem_rdata  = img(mem_addr);
        mem_rerr   = fetch_en && (mem_addr == fetch_bad_addr);
        cfg_ready  = !stall || cyc[0];
        cfg_err    = 1'b0;
        if (inj_port && !inj_done && state == 3'd4) begin
            cfg_err  = 1'b1;
            inj_done = 1;
        end
    end

    // Observe accepted words and reset cycles between edges.
    always @(negedge clk) begin
        if (cfg_valid && cfg_ready && npush < 64) begin
            pushed[npush] = cfg_data;
            npush++;
        end
        if (rm_reset) rst_hi++;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_trig(input logic [3:0] hw, input bit sw, input logic [1:0] sel);
        @(posedge clk); #2;
        hw_trig = hw; sw_trig = sw; sw_trig_sel = sel;
        @(posedge clk); #2;
        hw_trig = '0; sw_trig = 1'b0;
    endtask

    task automatic pulse_cmd(input bit restart);
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_restart = restart;
        @(posedge clk); #2;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (state == 3'd7 || state == 3'd0) break;
        end
    endtask

    // One load from trigger tid, with expected results computed from the requirements.
    task automatic run_load(input logic [3:0] hw, input bit sw, input int tid,
                            input bit port_e, input bit fetch_e, input bit stl);
        int rm, n, k, exp_n, bad;
        logic [3:0] exp_err;
        logic [31:0] a;
        rm = int'(map_b[tid]);
        stall = stl; inj_port = port_e; inj_done = 0;
        fetch_en = fetch_e;
        fetch_bad_addr = (rm < 4) ? base_b[rm] + 32'd4 : 32'hFFFF_FFFF;
        n = (rm < 4) ? int'((size_b[rm] + 32'd3) >> 2) : 0;
        if (rm >= 4)               exp_err = 4'd15;
        else if (n == 0)           exp_err = 4'd1;
        else if (port_e && fetch_e) exp_err = 4'd5;
        else if (port_e)           exp_err = 4'd2;
        else if (fetch_e)          exp_err = 4'd4;
        else                       exp_err = 4'd0;
        pulse_trig(hw, sw, 2'(tid));
        npush = 0; rst_hi = 0;
        @(negedge clk);
        chk("R3", "hw shutdown after trigger", 32'(state), 32'd1);
        chk("R2", "error cleared on accept", 32'(error), 32'd0);
        wait_end();
        chk("R8", "final error", 32'(error), 32'(exp_err));
        if (exp_err == 4'd15) chk("R7", "unknown map entry error", 32'(error), 32'd15);
        if (exp_err == 4'd1)  chk("R6", "zero size error", 32'(error), 32'd1);
        chk("R5", "final state", 32'(state), (exp_err == 0) ? 32'd7 : 32'd0);
        chk("R3", "module reset cycles", 32'(rst_hi), (exp_err == 0) ? 32'd4 : 32'd0);
        if (exp_err == 0) chk("R5", "loaded rm id", 32'(rm_id), 32'(rm));
        exp_n = (fetch_e && n >= 2) ? n - 1 : n;
        chk("R4", "forwarded word count", 32'(npush), 32'(exp_n));
        k = 0; bad = 0;
        for (int i = 0; i < n; i++) begin
            a = base_b[rm] + 32'(4 * i);
            if (!(fetch_e && a == fetch_bad_addr)) begin
                if (k < npush && pushed[k] !== img(a) && bad == 0) begin
                    chk("R4", "forwarded word value", pushed[k], img(a));
                    bad = 1;
                end
                k++;
            end
        end
        if (bad == 0) chk("R4", "word stream order", 32'd0, 32'd0);
        fetch_en = 0; inj_port = 0;
        repeat (3) @(posedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        map_b[0] = 3'd2; map_b[1] = 3'd0; map_b[2] = 3'd1; map_b[3] = 3'd5;
        for (int i = 0; i < 4; i++) base_b[i] = 32'h1000 + 32'(i) * 32'h100;
        size_b[0] = 32'd13; size_b[1] = 32'd0; size_b[2] = 32'd8; size_b[3] = 32'd1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1", "state", 32'(state), 32'd0);
        chk("R1", "error", 32'(error), 32'd0);
        chk("R1", "outputs idle", {28'd0, shutdown, rm_reset, mem_req, cfg_valid}, 32'd0);

        // R2 R3 R4 R5 R6 R7: every trigger, both sources, with and without stalls
        for (int sw = 0; sw < 2; sw++)
            for (int t = 0; t < 4; t++)
                for (int s = 0; s < 2; s++)
                    run_load(sw ? 4'd0 : 4'(1 << t), sw[0], t, 0, 0, s[0]);

        // R2: lowest hardware line wins, software beats hardware
        run_load(4'b1010, 0, 1, 0, 0, 0);
        run_load(4'b0001, 1, 2, 0, 0, 0);

        // R8: error injection on the four-word module
        run_load(4'b0010, 0, 1, 1, 0, 1);
        run_load(4'b0010, 0, 1, 0, 1, 0);
        run_load(4'b0010, 0, 1, 1, 1, 1);

        // R11: error held until restart
        run_load(4'b0100, 0, 2, 0, 0, 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R11", "error held", 32'(error), 32'd1);
        pulse_cmd(1);
        @(negedge clk);
        chk("R11", "restart clears error", 32'(error), 32'd0);

        // R4: byte size rounding sweep on module 3
        map_b[3] = 3'd3;
        for (int sz = 1; sz <= 9; sz++) begin
            size_b[3] = 32'(sz);
            run_load(4'b1000, 0, 3, 0, 0, sz[0]);
        end

        // R9: trigger during a transfer is dropped
        stall = 1;
        pulse_trig(4'b0001, 0, 2'd0);
        npush = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (state == 3'd4) break;
        end
        pulse_trig(4'b0000, 1, 2'd1);
        wait_end();
        chk("R9", "rm id unchanged by late trigger", 32'(rm_id), 32'd2);
        chk("R9", "word count of first load", 32'(npush), 32'd2);
        stall = 0;

        // R10 R9: shutdown from loaded, trigger dropped, restart back to loaded
        pulse_cmd(0);
        @(negedge clk);
        chk("R10", "parked state", 32'(state), 32'd2);
        chk("R10", "shutdown flag", 32'(shutdown), 32'd1);
        pulse_trig(4'b0010, 0, 2'd0);
        repeat (5) @(negedge clk);
        chk("R9", "trigger in shutdown dropped", {28'd0, state, mem_req}, {28'd0, 3'd2, 1'b0});
        pulse_cmd(1);
        @(negedge clk);
        chk("R10", "startup state", 32'(state), 32'd5);
        @(negedge clk);
        chk("R10", "back to loaded", 32'(state), 32'd7);
        chk("R10", "rm id kept", 32'(rm_id), 32'd2);
        chk("R10", "flag low after restart", 32'(shutdown), 32'd0);

        // R10: shutdown from empty returns to empty
        run_load(4'b0100, 0, 2, 0, 0, 0);
        pulse_cmd(0);
        @(negedge clk);
        chk("R10", "parked from empty", 32'(state), 32'd2);
        pulse_cmd(1);
        @(negedge clk);
        chk("R10", "startup from empty", 32'(state), 32'd5);
        @(negedge clk);
        chk("R10", "back to empty", 32'(state), 32'd0);

        // R9: command in the same cycle as a trigger wins
        @(posedge clk); #2;
        cmd_valid = 1'b1; cmd_restart = 1'b1; hw_trig = 4'b0001;
        @(posedge clk); #2;
        cmd_valid = 1'b0; hw_trig = '0;
        @(negedge clk);
        chk("R9", "trigger with command dropped", 32'(state), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule